// File: doc/BRIEF.md
# Dual-Plane Page Write Controller

This block sequences page-mode writes into a byte store that is split into two independent planes; the most significant address bit picks the plane. A host presents already demultiplexed write strobes, each carrying an address and a data byte. The first accepted strobe opens a page, and later strobes to the same page are gathered into a page buffer of up to 2^OFF_W bytes (32 by default). Every accepted byte restarts a byte-load window. When the window runs out with no new byte, the page closes and a program timer stands in for the slow nonvolatile write. When that timer ends, the buffered bytes are committed to the register array.

While a plane is programming, reads to that plane return a polling status in which only bit 6 is non-zero and flips on each read. Reads to the other plane return stored data at the same time. Reads are also allowed between the byte loads of a page, and they return the array contents from before the load. A write-inhibit input that is high during the page load drops the buffered page, so nothing is programmed. Timer lengths, the minimum spacing between bytes and the array depth are parameters counted in clock cycles.

The sequencer has three states. In IDLE, a strobe with the inhibit low opens the page (transition IDLE→LOAD). In LOAD, several things can happen: the inhibit aborts the page (LOAD→IDLE); an accepted byte restarts the window (LOAD→LOAD); expiry of the window starts programming (LOAD→PROG). In PROG, the program timer runs, and its last cycle commits the buffer (PROG→IDLE).

Top module: `dpw_ctrl`

## Requirements
- R1: After reset `busy` and `rd_valid` are 0 and every array byte reads as 0.
- R2: Bytes accepted during one page load are written to the array at their own addresses (page = address bits ADDR_W-1..OFF_W, slot = bits OFF_W-1..0). A later byte to the same slot replaces the earlier one. Slots that were not loaded keep their old contents.
- R3: The page closes, and `busy` rises, after exactly LOAD_WIN clock edges without an accepted byte following the last accepted one. A byte that arrives exactly LOAD_WIN edges after the previous one is still accepted and restarts the window.
- R4: `busy` stays high for exactly PROG_CYC cycles. A read issued in the cycle after `busy` falls returns the newly programmed data.
- R5: A read issued while `busy` is high, with address bit ADDR_W-1 equal to the busy plane, returns 8'h40 and then 8'h00, alternating on each such read. The first such read in each program cycle returns 8'h40.
- R6: A read issued while `busy` is high, to the other plane, returns the true stored byte.
- R7: A read issued during a page load returns the array contents as they were before the load, in either plane.
- R8: If `wr_inhibit` is high in any cycle of a page load, the page is dropped: `busy` stays low and the array is unchanged.
- R9: During a page load, a strobe whose page bits differ from the open page is ignored.
- R10: During a page load, a strobe that comes fewer than MIN_GAP edges after the previously accepted byte is ignored. The window keeps counting from that earlier byte.
- R11: Strobes are ignored while `busy` is high. In IDLE, a strobe with `wr_inhibit` high is also ignored.
- R12: `rd_valid` is high in the cycle after each `rd_stb`, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle byte write request (start of a write strobe) |
| wr_addr | input | ADDR_W | Write address; the top bit selects the plane |
| wr_data | input | DATA_W | Write data byte |
| wr_inhibit | input | 1 | High aborts an open page load and blocks new ones |
| rd_stb | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Read address; the top bit selects the plane |
| rd_data | output | DATA_W | Read result, valid when `rd_valid` is high |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_stb` |
| busy | output | 1 | High while a page is programming |

## Verification
Read results are registered, so they are due at the first clock edge after `rd_stb`. The bench samples them at the following falling edge, and `busy` is judged the same way. The bench's reference model advances on each rising edge using the inputs it drove at the preceding falling edge, and it is compared with the outputs at every falling edge. Expected outputs therefore line up with the design's registers cycle for cycle. In the directed checks, the window close is counted as LOAD_WIN falling edges after the returning write, and the busy length as PROG_CYC falling edges. Polled and programmed values are compared against literal constants.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } dpw_state_e;

    // data bit that flips on each status read of the busy plane
    localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/dpw_seq.sv
module dpw_seq
    import dpw_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 40,
    parameter int MIN_GAP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              wr_inhibit,
    output logic              accept,
    output logic              clear,
    output logic              start,
    output logic              commit,
    output logic              busy,
    output logic [PAGE_W-1:0] page_q
);
    localparam int CW = $clog2(LOAD_WIN + 1);
    localparam int PW = $clog2(PROG_CYC + 1);

    dpw_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [PW-1:0]     pcnt_q, pcnt_d;
    logic [PAGE_W-1:0] page_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
            page_q  <= page_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        page_d  = page_q;
        accept  = 1'b0;
        clear   = 1'b0;
        start   = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb && !wr_inhibit) begin
                    accept  = 1'b1;
                    page_d  = wr_page;
                    cnt_d   = '0;
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (wr_inhibit) begin
                    clear   = 1'b1;
                    state_d = ST_IDLE;
                end else if (wr_stb && (wr_page == page_q) &&
                             (cnt_q >= CW'(MIN_GAP - 1))) begin
                    accept = 1'b1;
                    cnt_d  = '0;
                end else if (cnt_q == CW'(LOAD_WIN - 1)) begin
                    start   = 1'b1;
                    pcnt_d  = '0;
                    state_d = ST_PROG;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_PROG: begin
                if (pcnt_q == PW'(PROG_CYC - 1)) begin
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    pcnt_d = pcnt_q + PW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_PROG);

    // R3: the load window counter never passes its last cycle
    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (cnt_q <= CW'(LOAD_WIN - 1)));
endmodule

// File: rtl/dpw_page_buf.sv
module dpw_page_buf #(
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [OFF_W-1:0]              slot,
    input  logic [DATA_W-1:0]             data,
    input  logic                          flush,
    output logic [(1<<OFF_W)*DATA_W-1:0]  slot_data,
    output logic [(1<<OFF_W)-1:0]         slot_vld
);
    localparam int SLOTS = 1 << OFF_W;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[g*DATA_W +: DATA_W] <= '0;
                slot_vld[g]                   <= 1'b0;
            end else if (flush) begin
                slot_vld[g] <= 1'b0;
            end else if (accept && (slot == OFF_W'(g))) begin
                slot_data[g*DATA_W +: DATA_W] <= data;
                slot_vld[g]                   <= 1'b1;
            end
        end
    end

    // R8: a dropped or committed page leaves no byte behind
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_vld == '0));
endmodule

// File: rtl/dpw_store.sv
module dpw_store
    import dpw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-OFF_W-1:0]       page,
    input  logic [(1<<OFF_W)*DATA_W-1:0]  slot_data,
    input  logic [(1<<OFF_W)-1:0]         slot_vld,
    input  logic                          start,
    input  logic                          busy,
    input  logic                          busy_plane,
    input  logic                          rd_stb,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_valid
);
    localparam int SLOTS = 1 << OFF_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] POLL_ONE = DATA_W'(1) << TOGGLE_BIT;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              tog_q;
    logic              poll;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_vld[i]) mem[{page, OFF_W'(i)}] <= slot_data[i*DATA_W +: DATA_W];
            end
        end
    end

    assign poll = busy && (rd_addr[ADDR_W-1] == busy_plane);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            tog_q    <= 1'b1;
        end else begin
            rd_valid <= rd_stb;
            if (start) begin
                tog_q <= 1'b1;
            end else if (rd_stb && poll) begin
                tog_q <= ~tog_q;
            end
            if (rd_stb) begin
                rd_data <= poll ? (tog_q ? POLL_ONE : '0) : mem[rd_addr];
            end
        end
    end

    // R5: a status read carries nothing but the toggle bit
    p_poll_only_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && poll) |=> ((rd_data & ~POLL_ONE) == '0));
endmodule

// File: rtl/dpw_ctrl.sv
module dpw_ctrl #(
    parameter int ADDR_W   = 9,
    parameter int OFF_W    = 5,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 40,
    parameter int MIN_GAP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_inhibit,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int SLOTS  = 1 << OFF_W;

    logic                      accept, clear, start, commit;
    logic [PAGE_W-1:0]         page_q;
    logic [SLOTS*DATA_W-1:0]   slot_data;
    logic [SLOTS-1:0]          slot_vld;

    dpw_seq #(
        .PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN),
        .PROG_CYC(PROG_CYC), .MIN_GAP(MIN_GAP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_page(wr_addr[ADDR_W-1:OFF_W]),
        .wr_inhibit(wr_inhibit),
        .accept(accept), .clear(clear), .start(start), .commit(commit),
        .busy(busy), .page_q(page_q)
    );

    dpw_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .slot(wr_addr[OFF_W-1:0]), .data(wr_data),
        .flush(clear | commit),
        .slot_data(slot_data), .slot_vld(slot_vld)
    );

    dpw_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .page(page_q),
        .slot_data(slot_data), .slot_vld(slot_vld),
        .start(start), .busy(busy), .busy_plane(page_q[PAGE_W-1]),
        .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R4: programming ends only through a commit
    p_busy_ends_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R2: a commit always has at least one loaded byte
    p_commit_has_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (slot_vld != '0));
endmodule

// File: tb/sim_dpw_ctrl.sv
module sim_dpw_ctrl;
    localparam int AW = 9;
    localparam int OW = 5;
    localparam int DW = 8;
    localparam int WIN = 16;
    localparam int PRG = 40;
    localparam int GAP = 3;
    localparam int PGW = AW - OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_inhibit = 1'b0;
    logic rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic rd_valid;
    logic busy;

    always #2 clk = ~clk;

    dpw_ctrl #(.ADDR_W(AW), .OFF_W(OW), .DATA_W(DW), .LOAD_WIN(WIN),
               .PROG_CYC(PRG), .MIN_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_inhibit(wr_inhibit), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy));

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference model
    int m_st = 0;            // 0 idle, 1 loading, 2 programming
    int m_cnt = 0, m_pc = 0, m_page = 0;
    bit m_tog = 1;
    int m_mem [1<<AW];
    int m_buf [1<<OW];
    bit m_bv [1<<OW];
    bit e_busy = 0, e_rv = 0;
    int e_rd = 0;

    function automatic int page_of(int a);
        return a >> OW;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_page = 0; m_tog = 1;
            foreach (m_mem[i]) m_mem[i] = 0;
            foreach (m_bv[i]) m_bv[i] = 0;
            e_busy = 0; e_rv = 0; e_rd = 0;
        end else begin
            e_rv = rd_stb;
            if (rd_stb) begin
                if (m_st == 2 && ((int'(rd_addr) >> (AW-1)) == (m_page >> (PGW-1)))) begin
                    e_rd = m_tog ? 64 : 0;
                    m_tog = !m_tog;
                end else begin
                    e_rd = m_mem[int'(rd_addr)];
                end
            end
            if (m_st == 0) begin
                if (wr_stb && !wr_inhibit) begin
                    m_st = 1; m_cnt = 0; m_page = page_of(int'(wr_addr));
                    m_buf[int'(wr_addr) % (1<<OW)] = int'(wr_data);
                    m_bv[int'(wr_addr) % (1<<OW)] = 1;
                end
            end else if (m_st == 1) begin
                if (wr_inhibit) begin
                    m_st = 0;
                    foreach (m_bv[i]) m_bv[i] = 0;
                end else if (wr_stb && page_of(int'(wr_addr)) == m_page && m_cnt >= GAP - 1) begin
                    m_buf[int'(wr_addr) % (1<<OW)] = int'(wr_data);
                    m_bv[int'(wr_addr) % (1<<OW)] = 1;
                    m_cnt = 0;
                end else if (m_cnt == WIN - 1) begin
                    m_st = 2; m_pc = 0; m_tog = 1;
                end else begin
                    m_cnt++;
                end
            end else begin
                if (m_pc == PRG - 1) begin
                    foreach (m_bv[i]) if (m_bv[i]) m_mem[m_page * (1<<OW) + i] = m_buf[i];
                    foreach (m_bv[i]) m_bv[i] = 0;
                    m_st = 0;
                end else begin
                    m_pc++;
                end
            end
            e_busy = (m_st == 2);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R12 covers rd_valid timing)
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "busy vs model", int'(busy), int'(e_busy));
            check("R12", "rd_valid vs model", int'(rd_valid), int'(e_rv));
            if (e_rv) check(cur_req, "rd_data vs model", int'(rd_data), e_rd);
        end
    end

    task automatic wr(int a, int d);
        wr_stb = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(string req, int a, int exp);
        rd_stb = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_stb = 1'b0;
        check("R12", "rd_valid", int'(rd_valid), 1);
        check(req, $sformatf("read %0h", a), int'(rd_data), exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy;
        for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    endtask

    task automatic wait_done;
        wait_busy();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        cur_req = "R1";
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "rd_valid after reset", int'(rd_valid), 0);
        rd("R1", 'h005, 0);

        cur_req = "R2";
        wr('h1A0, 'h11);
        rd("R7", 'h1A0, 0);
        idle(2);
        wr('h1A3, 'h22);
        idle(3);
        wr('h1A3, 'h33);
        rd("R7", 'h020, 0);
        idle(2);
        wr('h1BF, 'h44);
        wait_done();
        rd("R2", 'h1A0, 'h11);
        rd("R2", 'h1A3, 'h33);
        rd("R2", 'h1BF, 'h44);
        rd("R2", 'h1A1, 0);

        cur_req = "R5";
        wr('h040, 'h5A);
        idle(2);
        wr('h05F, 'hA5);
        wait_busy();
        rd("R5", 'h000, 'h40);
        rd("R5", 'h0FF, 'h00);
        rd("R5", 'h040, 'h40);
        rd("R6", 'h1A0, 'h11);
        rd("R6", 'h1BF, 'h44);
        rd("R5", 'h000, 'h00);
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        rd("R4", 'h040, 'h5A);
        rd("R4", 'h05F, 'hA5);

        cur_req = "R8";
        wr('h060, 'h77);
        idle(2);
        wr_inhibit = 1'b1;
        idle(1);
        wr_inhibit = 1'b0;
        idle(WIN + PRG + 4);
        check("R8", "busy after abort", int'(busy), 0);
        rd("R8", 'h060, 0);

        cur_req = "R9";
        wr('h080, 'h01);
        idle(3);
        wr('h0A1, 'h02);
        wait_done();
        rd("R9", 'h0A1, 0);
        rd("R9", 'h080, 'h01);

        cur_req = "R10";
        wr('h0C0, 'h03);
        wr('h0C1, 'h04);
        wait_done();
        rd("R10", 'h0C1, 0);
        rd("R10", 'h0C0, 'h03);

        cur_req = "R11";
        wr('h0E0, 'h05);
        wait_busy();
        wr('h0E2, 'h06);
        wait_done();
        wr_inhibit = 1'b1;
        wr('h0E3, 'h07);
        wr_inhibit = 1'b0;
        idle(WIN + 3);
        check("R11", "busy after inhibited write", int'(busy), 0);
        rd("R11", 'h0E2, 0);
        rd("R11", 'h0E3, 0);
        rd("R11", 'h0E0, 'h05);

        cur_req = "R3";
        wr('h100, 'h08);
        idle(WIN - 1);
        wr('h101, 'h09);
        n = 0;
        while (!busy && n < 200) begin @(negedge clk); n++; end
        check("R3", "edges to page close", n, WIN);
        n = 0;
        while (busy && n < 200) begin @(negedge clk); n++; end
        check("R4", "busy length", n, PRG);
        rd("R3", 'h100, 'h08);
        rd("R3", 'h101, 'h09);

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule